// File: doc/BRIEF.md
# Semaphore and Mailbox Interrupt Unit

This unit handles signalling between a host processor and a coprocessor. It holds two banks of sixteen single-bit semaphores and a set of command/reply mailbox pairs, three by default. The host reaches all of its registers through a simple 16-bit register bus. The coprocessor side has dedicated wires. It sees the host semaphores and the command words directly. It raises its own semaphores with set strobes, acknowledges commands with read strobes, and posts replies with write strobes.

The host gets one interrupt line. The line is raised when any coprocessor semaphore is pending and not masked, or when any reply is waiting to be read. Each coprocessor semaphore is cleared by writing a one to its bit in a clear register. Reading a reply register through the bus consumes that reply. Writing a command register marks the command pending toward the coprocessor until the coprocessor acknowledges it.

Top module: `smb_unit`

## Requirements
- R1: After reset, every host-readable register reads 0, `hsem_o`, `cmd_data_o` and `cmd_pend_o` are 0, and `irq_o` is 0.
- R2: Offset 0x10 is a read/write register of host-to-coprocessor flags. Its value drives `hsem_o`, and only a bus write to 0x10 changes it.
- R3: Offset 0x14 is a read/write mask. Mask bit i set to 1 keeps coprocessor semaphore i out of the interrupt, and 0 lets it in.
- R4: Offset 0x18 is write-only and always reads 0. Writing a 1 to bit i clears coprocessor semaphore i, and a 0 bit leaves that semaphore unchanged.
- R5: Offset 0x1C reads the coprocessor semaphores. Each bit set in `csem_set_i` during a cycle sets that semaphore at the clock edge. Bus writes to 0x1C are ignored.
- R6: When a set strobe and a clear write hit the same semaphore bit in the same cycle, the bit ends up set.
- R7: Command register k is at offset 0x20+8k. It is read/write, and its value drives `cmd_data_o[16k+15:16k]`. A bus write sets `cmd_pend_o[k]`. A pulse on `cmd_ack_i[k]` clears that flag. If both happen in the same cycle, the flag stays set.
- R8: Reply register k is at offset 0x24+8k and is read-only from the bus. A pulse on `rep_we_i[k]` stores `rep_data_i` and sets the reply's valid flag. A bus read of the register clears the valid flag, unless a reply write arrives in the same cycle. Bus writes to the register are ignored.
- R9: `irq_o` is registered. It equals the OR of all unmasked coprocessor semaphores and all reply valid flags as they stood one clock earlier, so it follows a state change by one cycle.
- R10: Reads of unmapped or misaligned addresses (address bits 1:0 not zero) return 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| hsem_o | output | 16 | Host-to-coprocessor semaphore flags |
| csem_set_i | input | 16 | Coprocessor semaphore set strobes |
| cmd_data_o | output | 48 | Command words, channel k in bits 16k+15:16k |
| cmd_pend_o | output | 3 | Command pending flags |
| cmd_ack_i | input | 3 | Coprocessor command acknowledge strobes |
| rep_we_i | input | 3 | Coprocessor reply write strobes |
| rep_data_i | input | 16 | Reply data for the strobed channel |
| irq_o | output | 1 | Host interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions between the two sides. One is a coprocessor set strobe landing in the same clock as a host clear of that bit. The other is a reply write landing in the same clock as the host read that would consume the previous reply. The bench drives the bus access and the coprocessor strobe from one task in a single clock period. It then reads the semaphore register or watches the interrupt to confirm that the set won. The one-cycle interrupt latency is checked by sampling the interrupt both in the cycle after the state change and in the cycle after that.

// File: rtl/smb_pkg.sv
package smb_pkg;
    // register offsets on the host bus
    localparam int unsigned OFS_HSEM     = 32'h10;
    localparam int unsigned OFS_MASK     = 32'h14;
    localparam int unsigned OFS_CLR      = 32'h18;
    localparam int unsigned OFS_CSEM     = 32'h1C;
    localparam int unsigned OFS_MBOX     = 32'h20;
    localparam int unsigned MBOX_STRIDE  = 8;
    localparam int unsigned MBOX_REP_OFS = 4;
endpackage

// File: rtl/smb_decode.sv
module smb_decode
    import smb_pkg::*;
#(
    parameter int unsigned AW  = 8,
    parameter int unsigned NCH = 3
) (
    input  logic           sel_i,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    output logic           hsem_we_o,
    output logic           mask_we_o,
    output logic           clr_we_o,
    output logic           hsem_re_o,
    output logic           mask_re_o,
    output logic           csem_re_o,
    output logic [NCH-1:0] cmd_we_o,
    output logic [NCH-1:0] cmd_re_o,
    output logic [NCH-1:0] rep_re_o
);
    logic wr_s;
    logic rd_s;

    always_comb begin
        wr_s      = sel_i & wr_i;
        rd_s      = sel_i & ~wr_i;
        hsem_we_o = wr_s && (addr_i == AW'(OFS_HSEM));
        mask_we_o = wr_s && (addr_i == AW'(OFS_MASK));
        clr_we_o  = wr_s && (addr_i == AW'(OFS_CLR));
        hsem_re_o = rd_s && (addr_i == AW'(OFS_HSEM));
        mask_re_o = rd_s && (addr_i == AW'(OFS_MASK));
        csem_re_o = rd_s && (addr_i == AW'(OFS_CSEM));
        for (int k = 0; k < NCH; k++) begin
            cmd_we_o[k] = wr_s && (addr_i == AW'(OFS_MBOX + k * MBOX_STRIDE));
            cmd_re_o[k] = rd_s && (addr_i == AW'(OFS_MBOX + k * MBOX_STRIDE));
            rep_re_o[k] = rd_s && (addr_i == AW'(OFS_MBOX + k * MBOX_STRIDE + MBOX_REP_OFS));
        end
    end
endmodule

// File: rtl/smb_sem_bank.sv
module smb_sem_bank #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // set is applied after clear so a colliding set survives
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/smb_mailbox.sv
module smb_mailbox #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we_i,
    input  logic [DW-1:0] cmd_wdata_i,
    input  logic          cmd_ack_i,
    input  logic          rep_we_i,
    input  logic [DW-1:0] rep_wdata_i,
    input  logic          rep_re_i,
    output logic [DW-1:0] cmd_o,
    output logic          pend_o,
    output logic [DW-1:0] rep_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [DW-1:0] cmd;
        logic          pend;
        logic [DW-1:0] rep;
        logic          valid;
    } mbox_t;

    mbox_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_ack_i) st_d.pend = 1'b0;
        if (cmd_we_i) begin
            st_d.cmd  = cmd_wdata_i;
            st_d.pend = 1'b1;
        end
        if (rep_re_i) st_d.valid = 1'b0;
        if (rep_we_i) begin
            st_d.rep   = rep_wdata_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o   = st_q.cmd;
    assign pend_o  = st_q.pend;
    assign rep_o   = st_q.rep;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/smb_unit.sv
module smb_unit
    import smb_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned NCH = 3,
    parameter int unsigned AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     hsem_o,
    input  logic [DW-1:0]     csem_set_i,
    output logic [NCH*DW-1:0] cmd_data_o,
    output logic [NCH-1:0]    cmd_pend_o,
    input  logic [NCH-1:0]    cmd_ack_i,
    input  logic [NCH-1:0]    rep_we_i,
    input  logic [DW-1:0]     rep_data_i,
    output logic              irq_o
);
    typedef struct packed {
        logic [DW-1:0] hsem;
        logic [DW-1:0] mask;
        logic          irq;
    } top_t;

    top_t top_d, top_q;

    logic                    hsem_we, mask_we, clr_we;
    logic                    hsem_re, mask_re, csem_re;
    logic [NCH-1:0]          cmd_we, cmd_re, rep_re;
    logic [DW-1:0]           clr_vec;
    logic [DW-1:0]           csem_q;
    logic [DW-1:0]           mask_cur;
    logic [NCH-1:0]          rep_valid;
    logic [NCH-1:0][DW-1:0]  cmd_w;
    logic [NCH-1:0][DW-1:0]  rep_w;

    smb_decode #(.AW(AW), .NCH(NCH)) u_dec (
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .hsem_we_o (hsem_we),
        .mask_we_o (mask_we),
        .clr_we_o  (clr_we),
        .hsem_re_o (hsem_re),
        .mask_re_o (mask_re),
        .csem_re_o (csem_re),
        .cmd_we_o  (cmd_we),
        .cmd_re_o  (cmd_re),
        .rep_re_o  (rep_re)
    );

    assign clr_vec = clr_we ? bus_wdata : '0;

    smb_sem_bank #(.W(DW)) u_csem (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (csem_set_i),
        .clr_i   (clr_vec),
        .flags_o (csem_q)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_mbox
        smb_mailbox #(.DW(DW)) u_mbox (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_we_i    (cmd_we[k]),
            .cmd_wdata_i (bus_wdata),
            .cmd_ack_i   (cmd_ack_i[k]),
            .rep_we_i    (rep_we_i[k]),
            .rep_wdata_i (rep_data_i),
            .rep_re_i    (rep_re[k]),
            .cmd_o       (cmd_w[k]),
            .pend_o      (cmd_pend_o[k]),
            .rep_o       (rep_w[k]),
            .valid_o     (rep_valid[k])
        );
        assign cmd_data_o[k*DW +: DW] = cmd_w[k];
    end

    always_comb begin
        top_d = top_q;
        if (hsem_we) top_d.hsem = bus_wdata;
        if (mask_we) top_d.mask = bus_wdata;
        top_d.irq = (|(csem_q & ~top_q.mask)) | (|rep_valid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hsem_re) bus_rdata = top_q.hsem;
        if (mask_re) bus_rdata = top_q.mask;
        if (csem_re) bus_rdata = csem_q;
        for (int k = 0; k < NCH; k++) begin
            if (cmd_re[k]) bus_rdata = cmd_w[k];
            if (rep_re[k]) bus_rdata = rep_w[k];
        end
    end

    assign mask_cur = top_q.mask;
    assign hsem_o   = top_q.hsem;
    assign irq_o    = top_q.irq;
endmodule

// File: rtl/smb_chk.sv
module smb_chk
    import smb_pkg::*;
#(
    parameter int unsigned DW  = 16,
    parameter int unsigned NCH = 3,
    parameter int unsigned AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  hsem,
    input logic [DW-1:0]  csem_set,
    input logic [DW-1:0]  csem,
    input logic [DW-1:0]  mask,
    input logic [NCH-1:0] cmd_we,
    input logic [NCH-1:0] cmd_ack,
    input logic [NCH-1:0] cmd_pend,
    input logic [NCH-1:0] rep_we,
    input logic [NCH-1:0] rep_re,
    input logic [NCH-1:0] rep_valid,
    input logic           irq
);
    logic hsem_wr, clr_wr;
    assign hsem_wr = bus_sel && bus_wr && (bus_addr == AW'(OFS_HSEM));
    assign clr_wr  = bus_sel && bus_wr && (bus_addr == AW'(OFS_CLR));

    // R2
    hsem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsem_wr |=> $stable(hsem));

    // R4
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && csem_set == '0) |=> ((csem & $past(bus_wdata)) == '0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|csem_set) |=> ((csem & $past(csem_set)) == $past(csem_set)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((csem & ~mask) == '0) && (rep_valid == '0)) |=> !irq);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(csem & ~mask)) |=> irq);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        // R7
        cmd_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_we[k] |=> cmd_pend[k]);
        // R7
        cmd_pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ack[k] && !cmd_we[k]) |=> !cmd_pend[k]);
        // R8
        rep_valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rep_we[k] |=> rep_valid[k]);
        // R8
        rep_valid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rep_re[k] && !rep_we[k]) |=> !rep_valid[k]);
    end
endmodule

bind smb_unit smb_chk #(.DW(DW), .NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hsem      (hsem_o),
    .csem_set  (csem_set_i),
    .csem      (csem_q),
    .mask      (mask_cur),
    .cmd_we    (cmd_we),
    .cmd_ack   (cmd_ack_i),
    .cmd_pend  (cmd_pend_o),
    .rep_we    (rep_we_i),
    .rep_re    (rep_re),
    .rep_valid (rep_valid),
    .irq       (irq_o)
);

// File: tb/sim_smb_unit.sv
`timescale 1ns/1ps
module sim_smb_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] hsem_o;
    logic [15:0] csem_set_i = '0;
    logic [47:0] cmd_data_o;
    logic [2:0]  cmd_pend_o;
    logic [2:0]  cmd_ack_i = '0;
    logic [2:0]  rep_we_i = '0;
    logic [15:0] rep_data_i = '0;
    logic        irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smb_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hsem_o(hsem_o), .csem_set_i(csem_set_i), .cmd_data_o(cmd_data_o),
        .cmd_pend_o(cmd_pend_o), .cmd_ack_i(cmd_ack_i), .rep_we_i(rep_we_i),
        .rep_data_i(rep_data_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VT [NV] = '{
        '{1'b0, 8'h10, 16'hA5C3, 4'd2},   // R2 write host flags
        '{1'b1, 8'h10, 16'hA5C3, 4'd2},   // R2
        '{1'b0, 8'h14, 16'h0F0F, 4'd3},   // R3
        '{1'b1, 8'h14, 16'h0F0F, 4'd3},   // R3
        '{1'b0, 8'h14, 16'hFFFF, 4'd3},   // R3
        '{1'b1, 8'h14, 16'hFFFF, 4'd3},   // R3
        '{1'b0, 8'h18, 16'h0000, 4'd4},   // R4 zero clear, no change
        '{1'b1, 8'h18, 16'h0000, 4'd4},   // R4 reads zero
        '{1'b0, 8'h1C, 16'hFFFF, 4'd5},   // R5 write ignored
        '{1'b1, 8'h1C, 16'h0000, 4'd5},   // R5
        '{1'b0, 8'h20, 16'h1234, 4'd7},   // R7
        '{1'b0, 8'h28, 16'h5678, 4'd7},   // R7
        '{1'b0, 8'h30, 16'h9ABC, 4'd7},   // R7
        '{1'b1, 8'h20, 16'h1234, 4'd7},   // R7
        '{1'b1, 8'h28, 16'h5678, 4'd7},   // R7
        '{1'b1, 8'h30, 16'h9ABC, 4'd7},   // R7
        '{1'b0, 8'h24, 16'hBEEF, 4'd8},   // R8 write ignored
        '{1'b1, 8'h24, 16'h0000, 4'd8},   // R8
        '{1'b0, 8'h12, 16'h5555, 4'd10},  // R10 misaligned write
        '{1'b1, 8'h10, 16'hA5C3, 4'd10},  // R10 flags untouched
        '{1'b0, 8'h40, 16'h7777, 4'd10},  // R10 unmapped
        '{1'b1, 8'h40, 16'h0000, 4'd10},  // R10
        '{1'b1, 8'h11, 16'h0000, 4'd10}   // R10 misaligned read
    };

    task automatic chk(input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic sem_pulse(input logic [15:0] v);
        @(negedge clk);
        csem_set_i = v;
        @(negedge clk);
        csem_set_i = '0;
    endtask

    task automatic rep_pulse(input logic [2:0] ch, input logic [15:0] d);
        @(negedge clk);
        rep_we_i = ch; rep_data_i = d;
        @(negedge clk);
        rep_we_i = '0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1", "irq", {47'd0, irq_o}, 48'd0);
        chk("R1", "hsem", {32'd0, hsem_o}, 48'd0);
        chk("R1", "pend", {45'd0, cmd_pend_o}, 48'd0);
        chk("R1", "cmd_data", cmd_data_o, 48'd0);
        for (int a = 8'h10; a <= 8'h34; a += 4) begin
            bus_read(8'(a), rd);
            chk("R1", $sformatf("read %h", a), {32'd0, rd}, 48'd0);
        end

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                bus_read(VT[i].addr, rd);
                chk($sformatf("R%0d", VT[i].req), $sformatf("vec %0d", i),
                    {32'd0, rd}, {32'd0, VT[i].data});
            end else begin
                bus_write(VT[i].addr, VT[i].data);
            end
        end
        chk("R2", "hsem_o", {32'd0, hsem_o}, {32'd0, 16'hA5C3});
        chk("R7", "pend after writes", {45'd0, cmd_pend_o}, 48'd7);
        chk("R7", "cmd_data_o", cmd_data_o, 48'h9ABC_5678_1234);

        // semaphores and interrupt
        bus_write(8'h14, 16'h0000);
        sem_pulse(16'h0003);
        chk("R9", "irq one cycle late", {47'd0, irq_o}, 48'd0);
        @(negedge clk);
        chk("R9", "irq raised", {47'd0, irq_o}, 48'd1);
        bus_read(8'h1C, rd);
        chk("R5", "csem after set", {32'd0, rd}, 48'h0003);
        bus_write(8'h14, 16'h0003);
        @(negedge clk);
        chk("R3", "all masked", {47'd0, irq_o}, 48'd0);
        bus_write(8'h14, 16'h0001);
        @(negedge clk);
        chk("R3", "bit1 unmasked", {47'd0, irq_o}, 48'd1);
        bus_write(8'h18, 16'h0002);
        bus_read(8'h1C, rd);
        chk("R4", "w1c bit1", {32'd0, rd}, 48'h0001);
        @(negedge clk);
        chk("R4", "irq after clear", {47'd0, irq_o}, 48'd0);

        // R6 set and clear in the same cycle
        @(negedge clk);
        csem_set_i = 16'h0100;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 16'h0101;
        @(negedge clk);
        csem_set_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(8'h1C, rd);
        chk("R6", "set wins", {32'd0, rd}, 48'h0100);

        bus_write(8'h18, 16'hFFFF);
        bus_read(8'h1C, rd);
        chk("R4", "clear all", {32'd0, rd}, 48'h0000);
        bus_write(8'h14, 16'h0000);
        @(negedge clk);
        chk("R9", "irq idle", {47'd0, irq_o}, 48'd0);

        // R7 command acknowledge
        @(negedge clk);
        cmd_ack_i = 3'b010;
        @(negedge clk);
        cmd_ack_i = '0;
        chk("R7", "ack clears", {45'd0, cmd_pend_o}, 48'd5);
        @(negedge clk);
        cmd_ack_i = 3'b001;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 16'h4321;
        @(negedge clk);
        cmd_ack_i = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R7", "write beats ack", {45'd0, cmd_pend_o}, 48'd5);
        chk("R7", "new cmd0", {32'd0, cmd_data_o[15:0]}, 48'h4321);

        // R8 replies
        rep_pulse(3'b100, 16'hCAFE);
        @(negedge clk);
        chk("R8", "reply irq", {47'd0, irq_o}, 48'd1);
        bus_read(8'h34, rd);
        chk("R8", "reply2 data", {32'd0, rd}, 48'hCAFE);
        @(negedge clk);
        chk("R8", "read consumes", {47'd0, irq_o}, 48'd0);

        rep_pulse(3'b010, 16'h1111);
        @(negedge clk);
        rep_we_i = 3'b010; rep_data_i = 16'h2222;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h2C;
        #1 rd = bus_rdata;
        @(negedge clk);
        rep_we_i = '0; bus_sel = 1'b0;
        chk("R8", "old reply read", {32'd0, rd}, 48'h1111);
        @(negedge clk);
        chk("R8", "write beats read", {47'd0, irq_o}, 48'd1);
        bus_read(8'h2C, rd);
        chk("R8", "new reply", {32'd0, rd}, 48'h2222);
        @(negedge clk);
        chk("R8", "valid gone", {47'd0, irq_o}, 48'd0);

        done = 1'b1;
        finish_run();
    end
endmodule